// File: doc/BRIEF.md
# Sub-Blocked Direct-Mapped Cache Controller

This block is the control and storage for a small direct-mapped cache whose lines are split into independently valid sub-blocks. The default configuration holds 1 KB as 32 lines of 32 bytes, and each line is divided into four 8-byte sub-blocks. A processor request names a 32-bit byte address, a read or write flag, eight byte enables and eight bytes of write data. A hit completes without any memory traffic.

A miss moves only the one 8-byte sub-block that the request needs. This applies to store misses as well, which allocate before the store merges. Writes update only the cache, and each line has a dirty flag. When a dirty line has to give way to a different tag, its valid sub-blocks are sent to memory one by one before the new sub-block is fetched.

The memory side moves one aligned 8-byte sub-block per transaction. It uses a request that is held until acknowledged. While the controller is writing back or fetching, it raises a stall to the processor and does not accept new requests.

Top module: `subblk_cache_ctrl`

## Requirements
- R1: The byte address splits as bits 2:0 byte lane (ignored by the controller), bits 4:3 sub-block number, bits 9:5 line index, and bits 31:10 tag. Every fill request carries the requested address with bits 2:0 cleared.
- R2: A request whose index holds a matching tag with the addressed sub-block valid completes with no memory transaction, and the block is ready again in the cycle after `cpu_done`.
- R3: A request whose tag matches but whose sub-block is invalid issues exactly one memory read, for that sub-block only. The line's other valid sub-blocks still hit afterwards.
- R4: A request whose tag differs from the stored tag invalidates all four sub-blocks of the line and then fetches only the addressed sub-block.
- R5: Replacing a dirty line first writes each of its valid sub-blocks to memory in ascending sub-block order, at the old tag's addresses, before the fetch. Invalid sub-blocks are skipped.
- R6: Replacing a clean line produces no memory write.
- R7: A store miss fetches the addressed sub-block before merging the store data (write-allocate).
- R8: A store changes only the bytes whose enable is set (enable bit n controls data bits 8n+7:8n) and marks the line dirty. A store with no enables set changes no data.
- R9: `cpu_stall` is high exactly while a writeback or fill is in progress. `cpu_ready` is high only when idle, and a memory request is only raised while stalled.
- R10: After reset every sub-block is invalid, every line is clean, the controller is idle and ready, and no memory request is raised.
- R11: A raised memory request keeps its address and direction unchanged until `mem_ack` is seen.
- R12: A read returns the most recent data stored to that sub-block address, whether it comes from the cache or from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 8 | Byte enables within the 8-byte sub-block |
| cpu_wdata | input | 64 | Store data |
| cpu_ready | output | 1 | Idle and accepting a request |
| cpu_stall | output | 1 | Writeback or fill in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 64 | Load data, valid while `cpu_done` is high |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write sub-block, 0 = read sub-block |
| mem_addr | output | 32 | Sub-block aligned memory address |
| mem_wdata | output | 64 | Writeback data |
| mem_ack | input | 1 | Transaction complete; read data valid |
| mem_rdata | input | 64 | Fill data |

## Verification
The properties assume that `mem_ack` arrives only while `mem_req` is high and lasts one cycle. They also assume that a new processor request is offered only while `cpu_ready` is high. The bench's memory responder acknowledges a held request after a fixed two-cycle wait and then drops the acknowledge for at least one cycle. The processor driver waits for `cpu_ready` before raising a one-cycle request and does not issue another until `cpu_done`. Under these conditions the writeback ordering and fill address properties can compare memory traffic against the last accepted address.

// File: rtl/subblk_cache_pkg.sv
package subblk_cache_pkg;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_WBACK = 2'd1,
        CS_FILL  = 2'd2,
        CS_REPLY = 2'd3
    } cache_state_e;

endpackage

// File: rtl/subblk_addr_split.sv
module subblk_addr_split #(
    parameter int UPPER_W = 29,
    parameter int SUB_W   = 2,
    parameter int IDX_W   = 5
) (
    input  logic [UPPER_W-1:0]             addr_upper,
    output logic [UPPER_W-SUB_W-IDX_W-1:0] tag,
    output logic [IDX_W-1:0]               idx,
    output logic [SUB_W-1:0]               sub
);
    localparam int TAG_W = UPPER_W - SUB_W - IDX_W;

    assign sub = addr_upper[SUB_W-1:0];
    assign idx = addr_upper[SUB_W +: IDX_W];
    assign tag = addr_upper[UPPER_W-1 -: TAG_W];
endmodule

// File: rtl/subblk_data_ram.sv
module subblk_data_ram #(
    parameter int ENTRIES = 128,
    parameter int BYTES   = 8,
    parameter int AW      = 7
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [BYTES-1:0]   wr_be,
    input  logic [BYTES*8-1:0] wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [BYTES*8-1:0] rd_data
);
    // One storage column per byte lane so each lane has a single writer.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane_q [ENTRIES];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_q[wr_addr] <= wr_data[b*8 +: 8];
            end
        end

        assign rd_data[b*8 +: 8] = lane_q[rd_addr];
    end
endmodule

// File: rtl/subblk_tag_dir.sv
module subblk_tag_dir #(
    parameter int LINES = 32,
    parameter int TAG_W = 22,
    parameter int SUBS  = 4,
    parameter int IDX_W = 5,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] line_idx,
    output logic [TAG_W-1:0] line_tag,
    output logic [SUBS-1:0]  line_valid,
    output logic             line_dirty,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             fill_en,
    input  logic [SUB_W-1:0] fill_sub,
    input  logic             mark_dirty
);
    logic [TAG_W-1:0] tag_q   [LINES];
    logic [SUBS-1:0]  valid_q [LINES];
    logic [LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i]   <= '0;
                valid_q[i] <= '0;
            end
            dirty_q <= '0;
        end else begin
            if (alloc_en) begin
                tag_q[line_idx]   <= alloc_tag;
                valid_q[line_idx] <= '0;
                dirty_q[line_idx] <= 1'b0;
            end
            if (fill_en) begin
                valid_q[line_idx][fill_sub] <= 1'b1;
            end
            if (mark_dirty) begin
                dirty_q[line_idx] <= 1'b1;
            end
        end
    end

    assign line_tag   = tag_q[line_idx];
    assign line_valid = valid_q[line_idx];
    assign line_dirty = dirty_q[line_idx];
endmodule

// File: rtl/subblk_cache_ctrl.sv
module subblk_cache_ctrl
    import subblk_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SUB_BYTES  = 8,
    parameter int NUM_LINES  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [SUB_BYTES-1:0]     cpu_be,
    input  logic [SUB_BYTES*8-1:0]   cpu_wdata,
    output logic                     cpu_ready,
    output logic                     cpu_stall,
    output logic                     cpu_done,
    output logic [SUB_BYTES*8-1:0]   cpu_rdata,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [SUB_BYTES*8-1:0]   mem_wdata,
    input  logic                     mem_ack,
    input  logic [SUB_BYTES*8-1:0]   mem_rdata
);
    localparam int SUBS    = LINE_BYTES / SUB_BYTES;
    localparam int DATA_W  = SUB_BYTES * 8;
    localparam int BE_W    = SUB_BYTES;
    localparam int LANE_W  = $clog2(SUB_BYTES);
    localparam int SUB_W   = $clog2(SUBS);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int OFF_W   = LANE_W + SUB_W;
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int ENTRIES = NUM_LINES * SUBS;
    localparam int EADR_W  = IDX_W + SUB_W;

    typedef struct packed {
        cache_state_e     st;
        logic             we;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [SUB_W-1:0] sub;
        logic [BE_W-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic [SUB_W-1:0] wb_sub;
    } ctl_t;

    ctl_t r_d, r_q;

    // Incoming address fields; the byte lane is not needed by the controller.
    logic [TAG_W-1:0] in_tag;
    logic [IDX_W-1:0] in_idx;
    logic [SUB_W-1:0] in_sub;
    logic             unused_lane;
    assign unused_lane = ^cpu_addr[LANE_W-1:0];

    subblk_addr_split #(
        .UPPER_W (ADDR_W - LANE_W),
        .SUB_W   (SUB_W),
        .IDX_W   (IDX_W)
    ) u_split (
        .addr_upper (cpu_addr[ADDR_W-1:LANE_W]),
        .tag        (in_tag),
        .idx        (in_idx),
        .sub        (in_sub)
    );

    // Directory
    logic [IDX_W-1:0] dir_idx;
    logic [TAG_W-1:0] dir_tag;
    logic [SUBS-1:0]  dir_valid;
    logic             dir_dirty;
    logic             alloc_en;
    logic [TAG_W-1:0] alloc_tag;
    logic             fill_en;
    logic             mark_dirty;

    assign dir_idx = (r_q.st == CS_IDLE) ? in_idx : r_q.idx;

    subblk_tag_dir #(
        .LINES (NUM_LINES),
        .TAG_W (TAG_W),
        .SUBS  (SUBS),
        .IDX_W (IDX_W),
        .SUB_W (SUB_W)
    ) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_idx   (dir_idx),
        .line_tag   (dir_tag),
        .line_valid (dir_valid),
        .line_dirty (dir_dirty),
        .alloc_en   (alloc_en),
        .alloc_tag  (alloc_tag),
        .fill_en    (fill_en),
        .fill_sub   (r_q.sub),
        .mark_dirty (mark_dirty)
    );

    // Data array
    logic              ram_we;
    logic [BE_W-1:0]   ram_be;
    logic [DATA_W-1:0] ram_wdata;
    logic [EADR_W-1:0] ram_rd_addr;
    logic [DATA_W-1:0] ram_rd_data;

    assign ram_rd_addr = (r_q.st == CS_WBACK) ? {r_q.idx, r_q.wb_sub}
                                              : {r_q.idx, r_q.sub};

    subblk_data_ram #(
        .ENTRIES (ENTRIES),
        .BYTES   (SUB_BYTES),
        .AW      (EADR_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (ram_we),
        .wr_addr ({r_q.idx, r_q.sub}),
        .wr_be   (ram_be),
        .wr_data (ram_wdata),
        .rd_addr (ram_rd_addr),
        .rd_data (ram_rd_data)
    );

    logic tag_hit;
    assign tag_hit = (dir_tag == in_tag);

    always_comb begin
        r_d        = r_q;
        alloc_en   = 1'b0;
        alloc_tag  = r_q.tag;
        fill_en    = 1'b0;
        mark_dirty = 1'b0;
        ram_we     = 1'b0;
        ram_be     = '0;
        ram_wdata  = mem_rdata;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {r_q.tag, r_q.idx, r_q.sub, {LANE_W{1'b0}}};
        mem_wdata  = ram_rd_data;
        cpu_done   = 1'b0;

        case (r_q.st)
            CS_IDLE: begin
                if (cpu_req) begin
                    r_d.we     = cpu_we;
                    r_d.tag    = in_tag;
                    r_d.idx    = in_idx;
                    r_d.sub    = in_sub;
                    r_d.be     = cpu_be;
                    r_d.wdata  = cpu_wdata;
                    r_d.wb_sub = '0;
                    if (tag_hit && dir_valid[in_sub]) begin
                        r_d.st = CS_REPLY;
                    end else if (!tag_hit && dir_dirty) begin
                        r_d.st = CS_WBACK;
                    end else begin
                        if (!tag_hit) begin
                            alloc_en  = 1'b1;
                            alloc_tag = in_tag;
                        end
                        r_d.st = CS_FILL;
                    end
                end
            end
            CS_WBACK: begin
                mem_we   = 1'b1;
                mem_addr = {dir_tag, r_q.idx, r_q.wb_sub, {LANE_W{1'b0}}};
                mem_req  = dir_valid[r_q.wb_sub];
                if (!dir_valid[r_q.wb_sub] || mem_ack) begin
                    if (r_q.wb_sub == SUB_W'(SUBS - 1)) begin
                        alloc_en = 1'b1;
                        r_d.st   = CS_FILL;
                    end else begin
                        r_d.wb_sub = r_q.wb_sub + 1'b1;
                    end
                end
            end
            CS_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    ram_we  = 1'b1;
                    ram_be  = '1;
                    fill_en = 1'b1;
                    r_d.st  = CS_REPLY;
                end
            end
            CS_REPLY: begin
                cpu_done = 1'b1;
                if (r_q.we) begin
                    ram_we     = 1'b1;
                    ram_be     = r_q.be;
                    ram_wdata  = r_q.wdata;
                    mark_dirty = 1'b1;
                end
                r_d.st = CS_IDLE;
            end
            default: r_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ready = (r_q.st == CS_IDLE);
    assign cpu_stall = (r_q.st == CS_WBACK) || (r_q.st == CS_FILL);
    assign cpu_rdata = ram_rd_data;
endmodule

// File: rtl/subblk_cache_chk.sv
module subblk_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 3,
    parameter int OFF_W  = 5,
    parameter int IDX_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cpu_req,
    input logic [ADDR_W-LANE_W-1:0] cpu_addr_upper,
    input logic                     cpu_ready,
    input logic                     cpu_stall,
    input logic                     cpu_done,
    input logic                     mem_req,
    input logic                     mem_we,
    input logic                     mem_ack,
    input logic [ADDR_W-1:0]        mem_addr
);
    localparam int HW = ADDR_W - LANE_W;
    localparam int HI = OFF_W - LANE_W;

    logic [HW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (cpu_req && cpu_ready) begin
            held_q <= cpu_addr_upper;
        end
    end

    AST_STALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (!cpu_ready && !cpu_done)); // R9

    AST_MEM_ONLY_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cpu_stall); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LANE_W-1:0] == '0)); // R1

    AST_FILL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:LANE_W] == held_q)); // R3

    AST_WB_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_addr[OFF_W +: IDX_W] == held_q[HI +: IDX_W])
                                 && (mem_addr[ADDR_W-1:OFF_W+IDX_W] != held_q[HW-1:HI+IDX_W]))); // R5

    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> cpu_ready); // R2
endmodule

bind subblk_cache_ctrl subblk_cache_chk #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req        (cpu_req),
    .cpu_addr_upper (cpu_addr[ADDR_W-1:LANE_W]),
    .cpu_ready      (cpu_ready),
    .cpu_stall      (cpu_stall),
    .cpu_done       (cpu_done),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_ack        (mem_ack),
    .mem_addr       (mem_addr)
);

// File: tb/tb_subblk_cache_ctrl.sv
`timescale 1ns/1ps
module tb_subblk_cache_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [7:0]  cpu_be = '0;
    logic [63:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_stall, cpu_done;
    logic [63:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    always #4 clk = ~clk;

    subblk_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    logic [63:0] back_mem [logic [28:0]];
    logic [63:0] gold_mem [logic [28:0]];

    logic [21:0] m_tag   [32];
    logic [3:0]  m_valid [32];
    bit          m_dirty [32];

    int          rsp_cnt = 0;
    int          n_rd = 0;
    int          n_wr = 0;
    logic [28:0] last_rd = '0;
    logic [28:0] wr_log [$];
    logic [31:0] hold_addr = '0;
    bit          stall_bad = 0;
    bit          hold_bad = 0;

    function automatic logic [63:0] pat(logic [28:0] k);
        return 64'(k) * 64'h9E37_79B9_7F4A_7C15 + 64'h0000_1234_0000_5678;
    endfunction

    function automatic logic [63:0] mem_val(logic [28:0] k);
        if (back_mem.exists(k)) return back_mem[k];
        return pat(k);
    endfunction

    function automatic logic [63:0] gold_val(logic [28:0] k);
        if (gold_mem.exists(k)) return gold_mem[k];
        return pat(k);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder: acknowledges after two held cycles, then drops ack.
    always @(negedge clk) begin
        if (mem_req && !cpu_stall) stall_bad = 1;
        if (mem_ack) begin
            mem_ack = 1'b0;
            rsp_cnt = 0;
        end else if (mem_req) begin
            rsp_cnt++;
            if (rsp_cnt == 1) hold_addr = mem_addr;
            else if (hold_addr != mem_addr) hold_bad = 1;
            if (rsp_cnt == 2) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    back_mem[mem_addr[31:3]] = mem_wdata;
                    n_wr++;
                    wr_log.push_back(mem_addr[31:3]);
                end else begin
                    mem_rdata = mem_val(mem_addr[31:3]);
                    n_rd++;
                    last_rd = mem_addr[31:3];
                end
            end
        end
    end

    task automatic access(input logic we, input logic [31:0] a, input logic [7:0] be,
                          input logic [63:0] wd, input string lbl);
        logic [21:0] t = a[31:10];
        logic [4:0]  ix = a[9:5];
        logic [1:0]  s = a[4:3];
        logic [28:0] key = a[31:3];
        logic [28:0] e_wkeys [$];
        int          e_rd = 0;
        string       rd_lbl;
        string       wr_lbl = "R6";
        logic [63:0] e_data;
        logic [63:0] g;
        logic [63:0] got;

        if (m_tag[ix] != t) begin
            rd_lbl = "R4";
            if (m_dirty[ix]) begin
                wr_lbl = "R5";
                for (int sb = 0; sb < 4; sb++)
                    if (m_valid[ix][sb]) e_wkeys.push_back({m_tag[ix], ix, 2'(sb)});
            end
            m_tag[ix] = t;
            m_valid[ix] = '0;
            m_dirty[ix] = 0;
        end else if (!m_valid[ix][s]) begin
            rd_lbl = "R3";
        end else begin
            rd_lbl = "R2";
        end
        if (!m_valid[ix][s]) e_rd = 1;
        if (we && e_rd == 1) rd_lbl = "R7";
        m_valid[ix][s] = 1'b1;
        e_data = gold_val(key);
        if (we) begin
            m_dirty[ix] = 1;
            g = e_data;
            for (int b = 0; b < 8; b++) if (be[b]) g[b*8 +: 8] = wd[b*8 +: 8];
            gold_mem[key] = g;
        end

        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        n_rd = 0; n_wr = 0; wr_log.delete(); stall_bad = 0; hold_bad = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) @(negedge clk);
        got = cpu_rdata;

        if (!we) chk(got == e_data, lbl, got, e_data);
        chk(n_rd == e_rd, rd_lbl, 64'(n_rd), 64'(e_rd));
        chk(n_wr == e_wkeys.size(), wr_lbl, 64'(n_wr), 64'(e_wkeys.size()));
        if (n_wr == e_wkeys.size()) begin
            foreach (e_wkeys[i]) chk(wr_log[i] == e_wkeys[i], "R5", 64'(wr_log[i]), 64'(e_wkeys[i]));
        end
        if (e_rd == 1) chk(last_rd == key, "R1", 64'(last_rd), 64'(key));
        chk(!stall_bad, "R9", 64'(stall_bad), 64'd0);
        chk(!hold_bad, "R11", 64'(hold_bad), 64'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R9 actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_tag[i] = '0; m_valid[i] = '0; m_dirty[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle, ready, quiet after reset
        chk(cpu_ready == 1'b1, "R10", 64'(cpu_ready), 64'd1);
        chk(cpu_stall == 1'b0, "R10", 64'(cpu_stall), 64'd0);
        chk(mem_req == 1'b0, "R10", 64'(mem_req), 64'd0);
        chk(cpu_done == 1'b0, "R10", 64'(cpu_done), 64'd0);

        // R10 / R3 / R4: every sub-block of every line starts invalid
        for (int ix = 0; ix < 32; ix++)
            for (int s = 0; s < 4; s++)
                access(1'b0, {22'd1, 5'(ix), 2'(s), 3'd0}, 8'h00, 64'd0, "R12");
        // R2: the same sweep now hits everywhere
        for (int ix = 0; ix < 32; ix++)
            for (int s = 0; s < 4; s++)
                access(1'b0, {22'd1, 5'(ix), 2'(s), 3'(ix)}, 8'h00, 64'd0, "R2");

        // R6 / R3: clean replacement, then partial fill keeping the other sub-block
        access(1'b0, {22'd2, 5'd0, 2'd2, 3'd0}, 8'h00, 64'd0, "R12");
        access(1'b0, {22'd2, 5'd0, 2'd0, 3'd5}, 8'h00, 64'd0, "R1");
        access(1'b0, {22'd2, 5'd0, 2'd2, 3'd7}, 8'h00, 64'd0, "R3");

        // R7 / R8: 16-bit stores, some allocating, then read back
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a = {22'd2, 5'(i), 2'(i % 4), 3'd0};
            logic [7:0]  be = 8'b11 << (2 * (i % 4));
            access(1'b1, a, be, {8{8'(i * 37 + 11)}}, "R8");
            access(1'b0, a, 8'h00, 64'd0, "R7");
        end

        // R8: every byte-enable pattern on one sub-block
        for (int e = 0; e < 256; e++) begin
            logic [31:0] a = {22'd4, 5'd20, 2'd1, 3'd0};
            access(1'b1, a, 8'(e), {8'(e), 8'(~e), 8'(e ^ 8'h5A), 8'(e + 1),
                                    8'(e * 3), 8'(e ^ 8'hC3), 8'(e - 7), 8'(e)}, "R8");
            access(1'b0, a, 8'h00, 64'd0, "R8");
        end

        // R5: evict every line with a new tag, dirty lines write back first
        for (int ix = 0; ix < 32; ix++)
            access(1'b0, {22'd3, 5'(ix), 2'd1, 3'd0}, 8'h00, 64'd0, "R12");

        // R5 / R12: memory now holds every stored value
        foreach (gold_mem[k]) chk(mem_val(k) == gold_mem[k], "R5", mem_val(k), gold_mem[k]);

        // R12: data written back is fetched again correctly
        for (int i = 0; i < 16; i++)
            access(1'b0, {22'd2, 5'(i), 2'(i % 4), 3'd0}, 8'h00, 64'd0, "R12");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule